// File: doc/BRIEF.md
# Two-step Vernier time-interval digitiser controller

This block controls and counts for a time-to-digital converter built from two gated ring oscillators of nearly equal period. A rising edge on the start input switches the slower ring on, and a coarse counter clocked by that ring counts its cycles. A rising edge on the stop input switches the faster ring on and freezes the coarse counter. A fine counter clocked by the fast ring then counts until a fast rising edge overtakes a slow rising edge. The coarse count resolves the interval in slow periods. The fine count resolves the residue in steps equal to the slow period minus the fast period.

Each ring has three stages of eight parallel drivers. For each stage the block turns a 3-bit driver-count field into a thermometer enable word, which is how the two rings are tuned apart. The finished measurement crosses into the system clock domain through a two-flop synchroniser. It is then offered on a valid/ready result port. `res_valid_o` rises once per measurement. The payload and valid hold steady while `res_ready_i` is low. The beat is consumed on the first cycle where valid and ready are both high. A pulse on `arm_i` clears every counter and flag and readies the block for the next start edge. A programmable fine limit bounds the fine phase with a timeout.

Top module: `vernier_tdc_ctrl`

## Requirements
- R1: A rising edge of `start_i` raises `slow_en_o`. The coarse count is the number of slow-ring rising edges seen from the start edge (the ring's first edge falls at that instant) until the rising edge of `stop_i`.
- R2: A rising edge of `stop_i` raises `fast_en_o`, and the coarse count stays frozen from then on.
- R3: The fine count is the number of fast-ring rising edges up to and including the first one that samples the slow ring high after an earlier fast edge sampled it low.
- R4: On that catching edge both `slow_en_o` and `fast_en_o` fall, and both counts stay frozen.
- R5: Suppose a fast edge brings the fine count to `fine_limit_i` and is not a catching edge. Then `res_timeout_o` is reported as 1, the fine count equals the limit, and both enables fall. A catch on the limit edge takes priority and reports timeout 0.
- R6: For each ring, stage s takes its driver count n from select bits [3s+2:3s]. Its word on drive bits [8s+7:8s] has the lowest n+1 bits set and the rest clear, registered one system cycle after the select.
- R7: `res_valid_o` rises after a measurement ends. While ready is low, valid and payload stay unchanged. After a cycle with valid and ready both high, valid falls and stays low until the next arm and measurement.
- R8: A cycle with `arm_i` high clears the counters, edge flags and ring enables, and holds `res_valid_o` low in the following cycle. A start edge before the arm is forgotten.
- R9: During reset `res_valid_o`, `slow_en_o` and `fast_en_o` are 0, and every stage drive word is 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Clear and re-arm for a new measurement |
| start_i | input | 1 | Interval start, rising edge |
| stop_i | input | 1 | Interval stop, rising edge |
| osc_slow_i | input | 1 | Slow ring output |
| osc_fast_i | input | 1 | Fast ring output |
| fine_limit_i | input | FINE_W | Fine count at which a timeout is declared (nonzero) |
| slow_sel_i | input | NSTAGE*3 | Slow ring driver counts, 3 bits per stage |
| fast_sel_i | input | NSTAGE*3 | Fast ring driver counts, 3 bits per stage |
| slow_en_o | output | 1 | Slow ring enable |
| fast_en_o | output | 1 | Fast ring enable |
| slow_drv_o | output | NSTAGE*NDRV | Slow ring thermometer driver enables |
| fast_drv_o | output | NSTAGE*NDRV | Fast ring thermometer driver enables |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result ready |
| res_coarse_o | output | COARSE_W | Coarse count |
| res_fine_o | output | FINE_W | Fine count |
| res_timeout_o | output | 1 | Fine phase ended by the limit |

## Verification
The catch detector and the timeout comparator can both act on the same fast edge, namely when the catching edge is exactly the one that brings the fine count to the limit. The bench first runs an interval with a generous limit to learn the catch index. It then repeats the same interval with the limit set to that index, where it expects the caught count with timeout 0. Finally it uses that index minus one, where it expects a timeout with the fine count equal to the limit.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  typedef enum logic [1:0] {
    RP_WAIT = 2'd0,
    RP_HOLD = 2'd1,
    RP_SPENT = 2'd2
  } rport_state_e;
endpackage

// File: rtl/tdc_drive_map.sv
`timescale 1ns/1ps
module tdc_drive_map #(
  parameter int NSTAGE = 3,
  parameter int NDRV = 8,
  localparam int SELW = $clog2(NDRV)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSTAGE*SELW-1:0]   sel_i,
  output logic [NSTAGE*NDRV-1:0]   drv_o
);
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    logic [SELW-1:0] n_drv;
    logic [NDRV-1:0] word_q;
    assign n_drv = sel_i[s*SELW +: SELW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= NDRV'(1);
      end else begin
        for (int j = 0; j < NDRV; j++) begin
          word_q[j] <= (j <= int'(n_drv));
        end
      end
    end
    assign drv_o[s*NDRV +: NDRV] = word_q;
  end
endmodule

// File: rtl/tdc_coarse.sv
`timescale 1ns/1ps
module tdc_coarse #(
  parameter int CNT_W = 12
) (
  input  logic             osc_i,
  input  logic             clr_i,
  input  logic             halt_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge osc_i or posedge clr_i) begin
    if (clr_i) begin
      cnt_o <= '0;
    end else if (!halt_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_fine.sv
`timescale 1ns/1ps
module tdc_fine #(
  parameter int CNT_W = 8
) (
  input  logic             osc_i,
  input  logic             clr_i,
  input  logic             slow_lvl_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             caught_o,
  output logic             tmo_o
);
  logic             seen_low;
  logic [CNT_W-1:0] cnt_nx;
  logic             ended;

  assign cnt_nx = cnt_o + 1'b1;
  assign ended  = caught_o | tmo_o;

  always_ff @(posedge osc_i or posedge clr_i) begin
    if (clr_i) begin
      cnt_o    <= '0;
      seen_low <= 1'b0;
      caught_o <= 1'b0;
      tmo_o    <= 1'b0;
    end else if (!ended) begin
      cnt_o <= cnt_nx;
      if (slow_lvl_i && seen_low) begin
        caught_o <= 1'b1;
      end else begin
        if (!slow_lvl_i) seen_low <= 1'b1;
        if (cnt_nx == limit_i) tmo_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdc_result_port.sv
`timescale 1ns/1ps
module tdc_result_port
  import tdc_pkg::*;
#(
  parameter int COARSE_W = 12,
  parameter int FINE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic                fin_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic                tmo_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic                tmo_o
);
  logic         sync1, sync2;
  rport_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else if (flush_i) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= fin_i;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RP_WAIT;
      coarse_o <= '0;
      fine_o   <= '0;
      tmo_o    <= 1'b0;
    end else if (flush_i) begin
      st <= RP_WAIT;
    end else begin
      case (st)
        RP_WAIT: if (sync2) begin
          coarse_o <= coarse_i;
          fine_o   <= fine_i;
          tmo_o    <= tmo_i;
          st       <= RP_HOLD;
        end
        RP_HOLD: if (ready_i) st <= RP_SPENT;
        default: st <= RP_SPENT;
      endcase
    end
  end

  assign valid_o = (st == RP_HOLD);
endmodule

// File: rtl/vernier_tdc_ctrl.sv
`timescale 1ns/1ps
module vernier_tdc_ctrl #(
  parameter int COARSE_W = 12,
  parameter int FINE_W = 8,
  parameter int NSTAGE = 3,
  parameter int NDRV = 8,
  localparam int SELW = $clog2(NDRV)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     osc_slow_i,
  input  logic                     osc_fast_i,
  input  logic [FINE_W-1:0]        fine_limit_i,
  input  logic [NSTAGE*SELW-1:0]   slow_sel_i,
  input  logic [NSTAGE*SELW-1:0]   fast_sel_i,
  output logic                     slow_en_o,
  output logic                     fast_en_o,
  output logic [NSTAGE*NDRV-1:0]   slow_drv_o,
  output logic [NSTAGE*NDRV-1:0]   fast_drv_o,
  output logic                     res_valid_o,
  input  logic                     res_ready_i,
  output logic [COARSE_W-1:0]      res_coarse_o,
  output logic [FINE_W-1:0]        res_fine_o,
  output logic                     res_timeout_o
);
  logic                arm_q, clr;
  logic                start_hit, stop_hit;
  logic                caught, tmo, fin;
  logic [COARSE_W-1:0] coarse_cnt;
  logic [FINE_W-1:0]   fine_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_i;
  end
  assign clr = arm_q | ~rst_n;

  always_ff @(posedge start_i or posedge clr) begin
    if (clr) start_hit <= 1'b0;
    else     start_hit <= 1'b1;
  end

  always_ff @(posedge stop_i or posedge clr) begin
    if (clr) stop_hit <= 1'b0;
    else     stop_hit <= 1'b1;
  end

  assign fin       = caught | tmo;
  assign slow_en_o = start_hit & ~fin;
  assign fast_en_o = stop_hit & ~fin;

  tdc_coarse #(.CNT_W(COARSE_W)) u_coarse (
    .osc_i  (osc_slow_i),
    .clr_i  (clr),
    .halt_i (stop_hit),
    .cnt_o  (coarse_cnt)
  );

  tdc_fine #(.CNT_W(FINE_W)) u_fine (
    .osc_i      (osc_fast_i),
    .clr_i      (clr),
    .slow_lvl_i (osc_slow_i),
    .limit_i    (fine_limit_i),
    .cnt_o      (fine_cnt),
    .caught_o   (caught),
    .tmo_o      (tmo)
  );

  tdc_drive_map #(.NSTAGE(NSTAGE), .NDRV(NDRV)) u_slow_map (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (slow_sel_i),
    .drv_o (slow_drv_o)
  );

  tdc_drive_map #(.NSTAGE(NSTAGE), .NDRV(NDRV)) u_fast_map (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (fast_sel_i),
    .drv_o (fast_drv_o)
  );

  tdc_result_port #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_rport (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (arm_i | arm_q),
    .fin_i    (fin),
    .coarse_i (coarse_cnt),
    .fine_i   (fine_cnt),
    .tmo_i    (tmo),
    .ready_i  (res_ready_i),
    .valid_o  (res_valid_o),
    .coarse_o (res_coarse_o),
    .fine_o   (res_fine_o),
    .tmo_o    (res_timeout_o)
  );
endmodule

// File: rtl/tdc_checker.sv
`timescale 1ns/1ps
module tdc_checker #(
  parameter int COARSE_W = 12,
  parameter int FINE_W = 8,
  parameter int NSTAGE = 3,
  parameter int NDRV = 8,
  localparam int SELW = $clog2(NDRV)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arm_i,
  input logic [FINE_W-1:0]      fine_limit_i,
  input logic [NSTAGE*SELW-1:0] slow_sel_i,
  input logic [NSTAGE*SELW-1:0] fast_sel_i,
  input logic                   slow_en_o,
  input logic                   fast_en_o,
  input logic [NSTAGE*NDRV-1:0] slow_drv_o,
  input logic [NSTAGE*NDRV-1:0] fast_drv_o,
  input logic                   res_valid_o,
  input logic                   res_ready_i,
  input logic [COARSE_W-1:0]    res_coarse_o,
  input logic [FINE_W-1:0]      res_fine_o,
  input logic                   res_timeout_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i && !arm_i |=> res_valid_o && $stable(res_coarse_o)
      && $stable(res_fine_o) && $stable(res_timeout_o));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_ready_i |=> !res_valid_o);

  p_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> !res_valid_o);

  p_rings_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !slow_en_o && !fast_en_o);

  p_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_timeout_o |-> res_fine_o == fine_limit_i);

  for (genvar s = 0; s < NSTAGE; s++) begin : g_drv
    p_slow_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> $countones(slow_drv_o[s*NDRV +: NDRV]) == int'($past(slow_sel_i[s*SELW +: SELW])) + 1);
    p_fast_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> $countones(fast_drv_o[s*NDRV +: NDRV]) == int'($past(fast_sel_i[s*SELW +: SELW])) + 1);
  end
endmodule

bind vernier_tdc_ctrl tdc_checker #(
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W),
  .NSTAGE   (NSTAGE),
  .NDRV     (NDRV)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .arm_i         (arm_i),
  .fine_limit_i  (fine_limit_i),
  .slow_sel_i    (slow_sel_i),
  .fast_sel_i    (fast_sel_i),
  .slow_en_o     (slow_en_o),
  .fast_en_o     (fast_en_o),
  .slow_drv_o    (slow_drv_o),
  .fast_drv_o    (fast_drv_o),
  .res_valid_o   (res_valid_o),
  .res_ready_i   (res_ready_i),
  .res_coarse_o  (res_coarse_o),
  .res_fine_o    (res_fine_o),
  .res_timeout_o (res_timeout_o)
);

// File: tb/vernier_tdc_ctrl_test.sv
`timescale 1ns/1ps
module vernier_tdc_ctrl_test;
  localparam int CW = 12;
  localparam int FW = 8;
  localparam int TS_PS = 10000;
  localparam int TF_PS = 9700;
  localparam int NV = 5;
  // stimulus: start-to-stop delay (ps) and fine limit; expected values computed by model()
  localparam int VEC_D [NV] = '{3250, 8150, 47650, 123450, 3250};
  localparam int VEC_L [NV] = '{200, 200, 200, 200, 10};

  logic clk = 0, rst_n = 0, arm = 0, start = 0, stop = 0;
  logic osc_s = 0, osc_f = 0, ready = 1;
  logic [FW-1:0] limit = 8'd200;
  logic [8:0] ssel = '0, fsel = '0;
  logic slow_en, fast_en, valid, tmo;
  logic [23:0] sdrv, fdrv;
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  vernier_tdc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .start_i(start), .stop_i(stop),
    .osc_slow_i(osc_s), .osc_fast_i(osc_f), .fine_limit_i(limit),
    .slow_sel_i(ssel), .fast_sel_i(fsel), .slow_en_o(slow_en), .fast_en_o(fast_en),
    .slow_drv_o(sdrv), .fast_drv_o(fdrv), .res_valid_o(valid), .res_ready_i(ready),
    .res_coarse_o(coarse), .res_fine_o(fine), .res_timeout_o(tmo)
  );

  always #10ns clk = ~clk;

  always begin
    wait (slow_en === 1'b1);
    osc_s = 1; #5ns; osc_s = 0; #5ns;
  end
  always begin
    wait (fast_en === 1'b1);
    osc_f = 1; #4.85ns; osc_f = 0; #4.85ns;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model(input int d, input int lim, output int ec, output int ef, output bit et);
    bit low_seen = 0;
    ec = (d - 1) / TS_PS + 1;
    ef = lim; et = 1;
    for (int i = 1; i <= lim; i++) begin
      int ph = (d + (i - 1) * TF_PS) % TS_PS;
      bit hi = (ph < TS_PS / 2);
      if (hi && low_seen) begin ef = i; et = 0; break; end
      if (!hi) low_seen = 1;
    end
  endtask

  task automatic run_meas(input int d, input int lim, input bit bp);
    int ec, ef, wc;
    bit et;
    logic [CW-1:0] c0;
    logic [FW-1:0] f0;
    model(d, lim, ec, ef, et);
    @(negedge clk);
    limit = FW'(lim); ready = !bp; arm = 1;
    @(negedge clk); arm = 0;
    repeat (3) @(negedge clk);
    #1ns start = 1;
    #10ps;
    chk(slow_en === 1'b1, "R1 slow enable after start", slow_en, 1);
    chk(fast_en === 1'b0, "R2 fast idle before stop", fast_en, 0);
    #((d - 10) * 1ps) stop = 1;
    #10ps;
    chk(fast_en === 1'b1, "R2 fast enable after stop", fast_en, 1);
    wc = 0;
    while (valid !== 1'b1 && wc < 3000) begin @(negedge clk); wc++; end
    chk(valid === 1'b1, "R7 result valid rises", valid, 1);
    chk(coarse == CW'(ec), "R1 R2 coarse count", coarse, ec);
    chk(fine == FW'(ef), "R3 fine count", fine, ef);
    chk(tmo == et, "R5 timeout flag", tmo, et);
    chk(!slow_en && !fast_en, "R4 rings off after end", {slow_en, fast_en}, 0);
    if (bp) begin
      c0 = coarse; f0 = fine;
      repeat (4) @(negedge clk);
      chk(valid === 1'b1 && coarse == c0 && fine == f0, "R7 hold under back-pressure", valid, 1);
      ready = 1;
      @(negedge clk);
    end
    @(negedge clk);
    chk(valid === 1'b0, "R7 valid drops after accept", valid, 0);
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R7 no second beat", valid, 0);
    start = 0; stop = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ec, ef, cidx;
    bit et;
    repeat (2) @(negedge clk);
    chk(valid === 1'b0, "R9 valid in reset", valid, 0);
    chk(!slow_en && !fast_en, "R9 rings off in reset", {slow_en, fast_en}, 0);
    chk(sdrv == 24'h010101 && fdrv == 24'h010101, "R9 drive words in reset", sdrv, 24'h010101);
    rst_n = 1;
    @(negedge clk);

    // R6: stage0 in bits [2:0]/[7:0]
    ssel = {3'd0, 3'd3, 3'd7};
    fsel = {3'd5, 3'd1, 3'd2};
    @(negedge clk);
    chk(sdrv == 24'h010FFF, "R6 slow drive words", sdrv, 24'h010FFF);
    chk(fdrv == 24'h3F0307, "R6 fast drive words", fdrv, 24'h3F0307);

    for (int v = 0; v < NV; v++) run_meas(VEC_D[v], VEC_L[v], 1'b0);

    // R5: catch and timeout on the same fast edge
    model(3250, 255, ec, cidx, et);
    chk(et == 0 && cidx > 2, "R3 model catch index", cidx, 3);
    run_meas(3250, cidx, 1'b0);
    run_meas(3250, cidx - 1, 1'b0);

    // R7 back-pressure
    run_meas(26750, 200, 1'b1);

    // R8: arm aborts a started measurement
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
    repeat (2) @(negedge clk);
    #1ns start = 1;
    #10ps;
    chk(slow_en === 1'b1, "R1 slow enable before abort", slow_en, 1);
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
    @(negedge clk);
    chk(slow_en === 1'b0, "R8 arm clears ring enable", slow_en, 0);
    chk(valid === 1'b0, "R8 no result after abort", valid, 0);
    start = 0;
    repeat (4) @(negedge clk);
    run_meas(64450, 200, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule